// File: doc/BRIEF.md
# Dual-Window Analog Watchdog Comparator

This block sits beside a successive approximation converter and watches two fixed input channels in hardware. Each conversion result is offered with its channel number and a one-cycle valid strobe. When the channel is one of the two watched ones, the value is checked against that channel's own upper and lower limits, with no software polling involved.

A value above the upper limit sets an "over" flag, and a value below the lower limit sets an "under" flag. A value equal to either limit counts as inside the window. The four flags are sticky. Software clears them by writing ones to the bits it wants cleared. One interrupt request, gated by an enable input, reports that any flag is set. Results from all other channels are ignored.

Top module: `awd_top`

## Requirements
- R1: After reset, `flags_o` is 0 and `irq_o` is low. Every upper limit resets to all ones and every lower limit to zero, so no value of either watched channel raises a flag until the limits are changed.
- R2: A valid result on watched channel A (default 6) whose value is strictly greater than limit A-high sets `flags_o[0]` at the next clock edge.
- R3: A valid result on channel A strictly less than limit A-low sets `flags_o[1]` at the next clock edge.
- R4: A value equal to the upper limit or to the lower limit sets no flag.
- R5: Watched channel B (default 7) has its own limits. B-over sets `flags_o[2]` and B-under sets `flags_o[3]`, and results on B leave bits 0 and 1 untouched.
- R6: Valid results on any channel other than A and B (channels 0 to 5 by default) leave `flags_o` unchanged, whatever their value.
- R7: A flag stays set until a cycle with `clr_we_i` high and a 1 in the same bit of `clr_mask_i`. Bits whose mask bit is 0 are kept.
- R8: When a set event and a clear of the same bit fall in the same cycle, the bit ends set.
- R9: `irq_o` is high exactly when `irq_en_i` is high and at least one bit of `flags_o` is set, in the same cycle.
- R10: If a channel's lower limit is above its upper limit, no special handling applies: every value on that channel sets at least one of its two flags, and a value between the two limits sets both.
- R11: A limit write takes effect at the clock edge that ends the write cycle. A result offered in that same cycle is compared against the old limit. The `thr_sel_i` codes are 0 = A-high, 1 = A-low, 2 = B-high, 3 = B-low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_valid_i | input | 1 | New conversion result strobe |
| res_ch_i | input | CH_W (3) | Channel of the result |
| res_data_i | input | DATA_W (8) | Converted value |
| thr_we_i | input | 1 | Limit register write strobe |
| thr_sel_i | input | 2 | Limit select: 0 A-high, 1 A-low, 2 B-high, 3 B-low |
| thr_wdata_i | input | DATA_W (8) | Limit write data |
| clr_we_i | input | 1 | Flag clear strobe |
| clr_mask_i | input | 4 | Write-one-to-clear mask for the flags |
| irq_en_i | input | 1 | Interrupt enable |
| flags_o | output | 4 | Sticky flags: [0] A-over, [1] A-under, [2] B-over, [3] B-under |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: 8-bit data, a 3-bit channel field, and channels 6 and 7 watched. With 8-bit data the extremes 0 and 255 are easy to reach. They are used to show that the reset limits flag nothing, and that results on the unwatched channels 0 to 5 are ignored even at full scale. The sequences also cover both boundaries of each window, a limit write in the same cycle as a result, a clear in the same cycle as a set, and an inverted window.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int NUM_WIN   = 2;
  localparam int FLAGS_PER = 2;
  localparam int NUM_FLAGS = NUM_WIN * FLAGS_PER;

  typedef enum logic [1:0] {
    THR_A_HI = 2'd0,
    THR_A_LO = 2'd1,
    THR_B_HI = 2'd2,
    THR_B_LO = 2'd3
  } thr_sel_e;
endpackage

// File: rtl/awd_limit_regs.sv
module awd_limit_regs
  import awd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [1:0]                     sel_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [NUM_WIN-1:0][DATA_W-1:0] hi_o,
  output logic [NUM_WIN-1:0][DATA_W-1:0] lo_o
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [1:0] HI_CODE = 2'(w * FLAGS_PER);
    localparam logic [1:0] LO_CODE = 2'(w * FLAGS_PER + 1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hi_o[w] <= '1;
        lo_o[w] <= '0;
      end else if (we_i) begin
        if (sel_i == HI_CODE) hi_o[w] <= wdata_i;
        if (sel_i == LO_CODE) lo_o[w] <= wdata_i;
      end
    end

    assert_limit_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_i |=> ($stable(hi_o[w]) && $stable(lo_o[w])));
  end
endmodule

// File: rtl/awd_window_cmp.sv
module awd_window_cmp #(
  parameter int DATA_W = 8
) (
  input  logic              hit_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic [DATA_W-1:0] lo_i,
  output logic              over_o,
  output logic              under_o
);
  // equality with either limit is in range
  always_comb begin
    over_o  = hit_i && (data_i > hi_i);
    under_o = hit_i && (data_i < lo_i);
  end
endmodule

// File: rtl/awd_flag_bank.sv
module awd_flag_bank #(
  parameter int NUM_FLAGS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_FLAGS-1:0] set_i,
  input  logic                 clr_we_i,
  input  logic [NUM_FLAGS-1:0] clr_mask_i,
  input  logic                 irq_en_i,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic                 irq_o
);
  logic [NUM_FLAGS-1:0] clr_eff;
  assign clr_eff = clr_we_i ? clr_mask_i : '0;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    // set beats clear so no event is lost
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         flags_o[i] <= 1'b0;
      else if (set_i[i])   flags_o[i] <= 1'b1;
      else if (clr_eff[i]) flags_o[i] <= 1'b0;
    end

    assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_o[i] && !(clr_we_i && clr_mask_i[i])) |=> flags_o[i]);
    assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flags_o[i]);
  end

  assign irq_o = irq_en_i && (|flags_o);

  assert_irq_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o == '0) |-> !irq_o);
endmodule

// File: rtl/awd_top.sv
module awd_top
  import awd_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CH_W    = 3,
  parameter int WATCH_A = 6,
  parameter int WATCH_B = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 res_valid_i,
  input  logic [CH_W-1:0]      res_ch_i,
  input  logic [DATA_W-1:0]    res_data_i,
  input  logic                 thr_we_i,
  input  logic [1:0]           thr_sel_i,
  input  logic [DATA_W-1:0]    thr_wdata_i,
  input  logic                 clr_we_i,
  input  logic [NUM_FLAGS-1:0] clr_mask_i,
  input  logic                 irq_en_i,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic                 irq_o
);
  localparam logic [NUM_WIN-1:0][CH_W-1:0] WATCH_CH = {CH_W'(WATCH_B), CH_W'(WATCH_A)};

  logic [NUM_WIN-1:0][DATA_W-1:0] thr_hi, thr_lo;
  logic [NUM_WIN-1:0]             hit;
  logic [NUM_FLAGS-1:0]           set_vec;

  awd_limit_regs #(.DATA_W(DATA_W)) u_limits (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (thr_we_i),
    .sel_i   (thr_sel_i),
    .wdata_i (thr_wdata_i),
    .hi_o    (thr_hi),
    .lo_o    (thr_lo)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    assign hit[w] = res_valid_i && (res_ch_i == WATCH_CH[w]);

    awd_window_cmp #(.DATA_W(DATA_W)) u_cmp (
      .hit_i   (hit[w]),
      .data_i  (res_data_i),
      .hi_i    (thr_hi[w]),
      .lo_i    (thr_lo[w]),
      .over_o  (set_vec[w*FLAGS_PER]),
      .under_o (set_vec[w*FLAGS_PER+1])
    );
  end

  awd_flag_bank #(.NUM_FLAGS(NUM_FLAGS)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (set_vec),
    .clr_we_i   (clr_we_i),
    .clr_mask_i (clr_mask_i),
    .irq_en_i   (irq_en_i),
    .flags_o    (flags_o),
    .irq_o      (irq_o)
  );

  assert_a_over_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && res_ch_i == CH_W'(WATCH_A) && res_data_i > thr_hi[0]) |=> flags_o[0]);
  assert_a_under_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && res_ch_i == CH_W'(WATCH_A) && res_data_i < thr_lo[0]) |=> flags_o[1]);
  assert_ignore_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(res_valid_i && (res_ch_i == CH_W'(WATCH_A) || res_ch_i == CH_W'(WATCH_B))) && !clr_we_i)
      |=> $stable(flags_o));
endmodule

// File: tb/tb_awd_top.sv
module tb_awd_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       res_valid = 1'b0;
  logic [2:0] res_ch = '0;
  logic [7:0] res_data = '0;
  logic       thr_we = 1'b0;
  logic [1:0] thr_sel = '0;
  logic [7:0] thr_wdata = '0;
  logic       clr_we = 1'b0;
  logic [3:0] clr_mask = '0;
  logic       irq_en = 1'b0;
  logic [3:0] flags;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [3:0] flags;
    logic       irq;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  logic [7:0] m_hi[2];
  logic [7:0] m_lo[2];
  logic [3:0] m_flags;

  always #2 clk = ~clk;

  awd_top dut (
    .clk_i(clk), .rst_ni(rst_n), .res_valid_i(res_valid), .res_ch_i(res_ch),
    .res_data_i(res_data), .thr_we_i(thr_we), .thr_sel_i(thr_sel),
    .thr_wdata_i(thr_wdata), .clr_we_i(clr_we), .clr_mask_i(clr_mask),
    .irq_en_i(irq_en), .flags_o(flags), .irq_o(irq)
  );

  task automatic drive(input logic v, input logic [2:0] ch, input logic [7:0] d,
                       input logic we, input logic [1:0] sel, input logic [7:0] wd,
                       input logic cw, input logic [3:0] cm, input logic en,
                       input string tag);
    logic [3:0] set_v;
    exp_t e;
    @(negedge clk);
    res_valid = v; res_ch = ch; res_data = d;
    thr_we = we; thr_sel = sel; thr_wdata = wd;
    clr_we = cw; clr_mask = cm; irq_en = en;
    set_v = '0;
    for (int w = 0; w < 2; w++) begin
      if (v && ch == 3'(6 + w)) begin
        if (d > m_hi[w]) set_v[2*w]   = 1'b1;
        if (d < m_lo[w]) set_v[2*w+1] = 1'b1;
      end
    end
    m_flags = set_v | (m_flags & ~(cw ? cm : 4'b0));
    if (we) begin
      if (sel[0]) m_lo[sel[1]] = wd;
      else        m_hi[sel[1]] = wd;
    end
    e.flags = m_flags;
    e.irq = en && (|m_flags);
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic res(input logic [2:0] ch, input logic [7:0] d, input logic en, input string tag);
    drive(1'b1, ch, d, 1'b0, 2'd0, 8'd0, 1'b0, 4'd0, en, tag);
  endtask

  task automatic wthr(input logic [1:0] sel, input logic [7:0] wd, input logic en, input string tag);
    drive(1'b0, 3'd0, 8'd0, 1'b1, sel, wd, 1'b0, 4'd0, en, tag);
  endtask

  task automatic clr(input logic [3:0] cm, input logic en, input string tag);
    drive(1'b0, 3'd0, 8'd0, 1'b0, 2'd0, 8'd0, 1'b1, cm, en, tag);
  endtask

  // monitor: compare just after each edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (flags !== e.flags || irq !== e.irq) begin
        errors++;
        $display("FAIL %s: flags=%b irq=%b expected flags=%b irq=%b",
                 e.tag, flags, irq, e.flags, e.irq);
      end
    end
  end

  initial begin
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_hi[0] = 8'hFF; m_hi[1] = 8'hFF; m_lo[0] = 8'h00; m_lo[1] = 8'h00;
    m_flags = '0;
    #9 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (flags !== 4'b0 || irq !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: flags=%b irq=%b expected 0000 0", flags, irq);
    end

    res(3'd6, 8'hFF, 1'b1, "R1 full scale at reset limits");
    res(3'd7, 8'h00, 1'b1, "R1 zero at reset limits");
    wthr(2'd0, 8'h80, 1'b1, "R11 write A-high");
    // limit write and result in the same cycle: old lower limit 0 applies
    drive(1'b1, 3'd6, 8'h10, 1'b1, 2'd1, 8'h20, 1'b0, 4'd0, 1'b1, "R11 same-cycle write");
    res(3'd6, 8'h80, 1'b1, "R4 equal upper");
    res(3'd6, 8'h20, 1'b1, "R4 equal lower");
    res(3'd6, 8'h81, 1'b1, "R2 A over and R9 irq");
    clr(4'b0000, 1'b1, "R7 zero mask keeps");
    clr(4'b0001, 1'b1, "R7 clear bit0");
    res(3'd6, 8'h1F, 1'b1, "R3 A under");
    for (int c = 0; c < 6; c++) begin
      res(3'(c), 8'hFF, 1'b1, "R6 ignored channel high");
      res(3'(c), 8'h00, 1'b1, "R6 ignored channel low");
    end
    wthr(2'd2, 8'h10, 1'b1, "R5 write B-high");
    wthr(2'd3, 8'h08, 1'b1, "R5 write B-low");
    res(3'd7, 8'h11, 1'b1, "R5 B over");
    res(3'd7, 8'h07, 1'b1, "R5 B under");
    res(3'd7, 8'h10, 1'b1, "R5 B equal upper");
    clr(4'b1111, 1'b1, "R7 clear all");
    res(3'd7, 8'h50, 1'b1, "R5 B over leaves A bits");
    drive(1'b1, 3'd7, 8'h50, 1'b0, 2'd0, 8'd0, 1'b1, 4'b0100, 1'b1, "R8 set wins over clear");
    res(3'd6, 8'h90, 1'b0, "R9 irq gated off");
    clr(4'b1111, 1'b0, "R9 cleared disabled");
    res(3'd6, 8'h90, 1'b1, "R9 irq enabled");
    clr(4'b1111, 1'b1, "R9 irq drops after clear");
    wthr(2'd0, 8'h10, 1'b1, "R10 A-high low");
    wthr(2'd1, 8'h90, 1'b1, "R10 A-low high");
    res(3'd6, 8'h50, 1'b1, "R10 between sets both");
    clr(4'b1111, 1'b1, "R10 clear");
    res(3'd6, 8'h00, 1'b1, "R10 zero sets under");
    clr(4'b1111, 1'b1, "R10 clear again");
    res(3'd6, 8'hFF, 1'b1, "R10 full sets over");
    drive(1'b0, 3'd0, 8'd0, 1'b0, 2'd0, 8'd0, 1'b0, 4'd0, 1'b1, "R7 idle holds");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule